// File: doc/BRIEF.md
# Unit Safety Guard with Fault Latch and Neighbour Signalling

This block sits inside one unit of a ring of cooperating motion units, between the unit's motion controller, its low-level I/O and the two adjacent units. Each cycle it inspects three things. The first is the drive command the controller sends to the motor: its magnitude, and its direction against the end switches. The second is the position reading that comes back from the encoder. The third is the error lines from both neighbours. Any violation is captured in a registered fault vector.

A mapping stage turns the fault vector into three safe-state messages: one for the local controller, one for the upstream unit and one for the downstream unit. An arbitration state machine then chooses the single state code that goes to the local controller. The candidates are a latched safe state, a user-interface command and a controller request. The state machine has two states, `ARB_RUN` and `ARB_LATCHED`. The transition `trip` (from `ARB_RUN` to `ARB_LATCHED`) fires when any fault bit is registered. The transition `release` (from `ARB_LATCHED` to `ARB_RUN`) fires when the clear input is high and no fault bit is registered. In every other case the state machine stays where it is.

While latched, the block raises an override flag. If the cause is local, it also sends hold messages to both neighbours: the upstream unit stops supplying and the downstream unit releases. State codes are 4 bits wide, and code 0 is reserved as the safe/idle state.

Top module: `unit_guard`

## Requirements
- R1: In reset, and after it, `fwd_state` is 0 (safe), `override_o`, `prev_err_o` and `next_err_o` are 0, and `prev_msg` and `next_msg` are 0.
- R2: In `ARB_RUN` with no fault, a cycle with `ui_valid` high loads `ui_state` into `fwd_state` at the next rising edge. A cycle with only `ctl_valid` high loads `ctl_state` instead. If both are high, the user state is the one loaded. With neither high, `fwd_state` holds its value.
- R3: A drive fault is raised when the magnitude of the two's-complement `pwm_cmd` exceeds `pwm_limit`. A magnitude equal to the limit is not a fault, and negative commands are checked by magnitude.
- R4: An encoder fault is raised when the signed `enc_pos` is below `enc_min` or above `enc_max`. Both bounds are themselves legal.
- R5: An end-switch fault is raised when `sw_hi` is high while `pwm_cmd` is positive, or when `sw_lo` is high while `pwm_cmd` is negative. Driving away from an active switch is not a fault.
- R6: When a fault condition is present at the ports before rising edge k, `override_o` is still 0 after edge k and becomes 1 after edge k+1.
- R7: While latched, `fwd_state` is 0 and `override_o` is 1, and both `ui_valid` and `ctl_valid` are ignored.
- R8: A local fault (drive, encoder or end switch) raises both `prev_err_o` and `next_err_o`. In that case `prev_msg` is `UP_CODE` (default 4'hA) and `next_msg` is `DN_CODE` (default 4'hB). Whenever those error outputs are low, both messages are 0.
- R9: A high `prev_err_in` or `next_err_in` latches the local safe state with `override_o` high, but it is not echoed on `prev_err_o`/`next_err_o`. A local fault that arrives later, while the unit is still latched, raises them.
- R10: The latch is released only at an edge where `clear_req` is high and no fault is registered. After the release, `fwd_state` stays 0 until a new request arrives.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| pwm_cmd | input | PWM_W | Signed drive command from controller |
| pwm_limit | input | PWM_W-1 | Largest allowed drive magnitude |
| enc_pos | input | ENC_W | Signed encoder position |
| enc_min | input | ENC_W | Lowest legal position (signed) |
| enc_max | input | ENC_W | Highest legal position (signed) |
| sw_hi | input | 1 | End switch at the positive travel end |
| sw_lo | input | 1 | End switch at the negative travel end |
| prev_err_in | input | 1 | Error line from upstream unit |
| next_err_in | input | 1 | Error line from downstream unit |
| ui_valid | input | 1 | User-interface command present |
| ui_state | input | 4 | User-interface state code |
| ctl_valid | input | 1 | Controller state request present |
| ctl_state | input | 4 | Controller requested state code |
| clear_req | input | 1 | Request to release the fault latch |
| fwd_state | output | 4 | State code forwarded to local controller |
| override_o | output | 1 | High while the fault latch is held |
| prev_err_o | output | 1 | Error line to upstream unit |
| prev_msg | output | 4 | Safe-state message to upstream unit |
| next_err_o | output | 1 | Error line to downstream unit |
| next_msg | output | 4 | Safe-state message to downstream unit |

## Verification
The hardest situation to reach is a latch that first trips on a neighbour's error line and is then upgraded by a local fault that arrives while it is still held. In that case the outbound error lines must rise without any new `trip` transition. The stimulus holds `prev_err_in` high until the latch is set, then adds an end-switch violation on top. It checks that the error outputs go from low to high while `override_o` stays high. A second hard case is a clear request issued while the condition persists, and again in the cycle the condition disappears. Because the fault vector is registered one edge behind the ports, the second case only releases on the following edge.

// File: rtl/unit_guard_pkg.sv
package unit_guard_pkg;

    localparam int STATE_W = 4;
    typedef logic [STATE_W-1:0] ustate_t;

    // Reserved safe / idle code
    localparam ustate_t SAFE_CODE = '0;

    // Fault vector layout; a lower index wins when several bits are set.
    // Indices below N_LOCAL are faults detected in this unit.
    localparam int FB_ENDSW    = 0;
    localparam int FB_ENC      = 1;
    localparam int FB_PWM      = 2;
    localparam int FB_NBR_NEXT = 3;
    localparam int FB_NBR_PREV = 4;
    localparam int N_FAULTS    = 5;
    localparam int N_LOCAL     = 3;

    typedef enum logic [0:0] {
        ARB_RUN,
        ARB_LATCHED
    } arb_state_t;

endpackage

// File: rtl/guard_catcher.sv
module guard_catcher
    import unit_guard_pkg::*;
#(
    parameter int PWM_W = 12,
    parameter int ENC_W = 16
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic signed [PWM_W-1:0] pwm_cmd,
    input  logic        [PWM_W-2:0] pwm_limit,
    input  logic signed [ENC_W-1:0] enc_pos,
    input  logic signed [ENC_W-1:0] enc_min,
    input  logic signed [ENC_W-1:0] enc_max,
    input  logic                    sw_hi,
    input  logic                    sw_lo,
    input  logic                    prev_err_in,
    input  logic                    next_err_in,
    output logic [N_FAULTS-1:0]     fault_q
);

    localparam int MAG_W = PWM_W;

    logic             pwm_neg;
    logic             pwm_pos;
    logic [MAG_W-1:0] pwm_mag;
    logic [MAG_W-1:0] limit_ext;
    logic [N_FAULTS-1:0] raw;

    // Magnitude of a two's-complement command; the most negative value
    // maps to 2^(PWM_W-1), which still fits as an unsigned PWM_W value.
    always_comb begin
        pwm_neg   = pwm_cmd[PWM_W-1];
        pwm_pos   = !pwm_neg && (pwm_cmd != '0);
        pwm_mag   = pwm_neg ? (~pwm_cmd + 1'b1) : pwm_cmd;
        limit_ext = {1'b0, pwm_limit};
    end

    // Sanity checks and incoming neighbour errors
    always_comb begin
        raw              = '0;
        raw[FB_PWM]      = pwm_mag > limit_ext;
        raw[FB_ENC]      = (enc_pos < enc_min) || (enc_pos > enc_max);
        raw[FB_ENDSW]    = (sw_hi && pwm_pos) || (sw_lo && pwm_neg);
        raw[FB_NBR_PREV] = prev_err_in;
        raw[FB_NBR_NEXT] = next_err_in;
    end

    // One capture register per fault source
    for (genvar g = 0; g < N_FAULTS; g++) begin : g_cap
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                fault_q[g] <= 1'b0;
            end else begin
                fault_q[g] <= raw[g];
            end
        end
    end

endmodule

// File: rtl/guard_mapper.sv
module guard_mapper
    import unit_guard_pkg::*;
#(
    parameter ustate_t UP_CODE = 4'hA,
    parameter ustate_t DN_CODE = 4'hB
) (
    input  logic [N_FAULTS-1:0] fault_vec,
    output logic                any_fault,
    output logic                local_hit,
    output ustate_t             own_msg,
    output ustate_t             up_msg,
    output ustate_t             dn_msg
);

    logic [N_LOCAL-1:0] local_bits;

    always_comb begin
        local_bits = fault_vec[N_LOCAL-1:0];
        any_fault  = |fault_vec;
        local_hit  = |local_bits;
    end

    // Fan a fault out into three safe-state messages. The local unit always
    // goes to the reserved code; neighbours get hold codes only when the
    // cause lies in this unit, so that an error does not circulate the ring.
    always_comb begin
        own_msg = SAFE_CODE;
        up_msg  = local_hit ? UP_CODE : SAFE_CODE;
        dn_msg  = local_hit ? DN_CODE : SAFE_CODE;
    end

endmodule

// File: rtl/guard_arbiter.sv
module guard_arbiter
    import unit_guard_pkg::*;
(
    input  logic    clk,
    input  logic    rst_n,
    input  logic    any_fault,
    input  logic    local_hit,
    input  ustate_t own_msg,
    input  ustate_t up_msg,
    input  ustate_t dn_msg,
    input  logic    clear_req,
    input  logic    ui_valid,
    input  ustate_t ui_state,
    input  logic    ctl_valid,
    input  ustate_t ctl_state,
    output ustate_t fwd_state,
    output logic    override_o,
    output logic    nbr_err_o,
    output ustate_t up_msg_o,
    output ustate_t dn_msg_o
);

    arb_state_t st_q, st_nx;
    ustate_t    fwd_q;
    ustate_t    own_q;
    ustate_t    up_q;
    ustate_t    dn_q;
    logic       tell_q;
    logic       release_ok;

    assign release_ok = clear_req && !any_fault;

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= ARB_RUN;
        end else begin
            st_q <= st_nx;
        end
    end

    // Transitions: trip and release
    always_comb begin
        st_nx = st_q;
        unique case (st_q)
            ARB_RUN:     if (any_fault)  st_nx = ARB_LATCHED;
            ARB_LATCHED: if (release_ok) st_nx = ARB_RUN;
            default:     st_nx = ARB_RUN;
        endcase
    end

    // Data held alongside the state
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            fwd_q  <= SAFE_CODE;
            own_q  <= SAFE_CODE;
            up_q   <= SAFE_CODE;
            dn_q   <= SAFE_CODE;
            tell_q <= 1'b0;
        end else begin
            unique case (st_q)
                ARB_RUN: begin
                    if (any_fault) begin
                        fwd_q  <= SAFE_CODE;
                        own_q  <= own_msg;
                        up_q   <= up_msg;
                        dn_q   <= dn_msg;
                        tell_q <= local_hit;
                    end else if (ui_valid) begin
                        fwd_q <= ui_state;
                    end else if (ctl_valid) begin
                        fwd_q <= ctl_state;
                    end
                end
                ARB_LATCHED: begin
                    if (release_ok) begin
                        fwd_q  <= SAFE_CODE;
                        tell_q <= 1'b0;
                        up_q   <= SAFE_CODE;
                        dn_q   <= SAFE_CODE;
                    end else if (local_hit && !tell_q) begin
                        // A local cause upgrades a neighbour-caused latch
                        tell_q <= 1'b1;
                        up_q   <= up_msg;
                        dn_q   <= dn_msg;
                    end
                end
                default: begin
                    fwd_q <= SAFE_CODE;
                end
            endcase
        end
    end

    // Outputs
    always_comb begin
        fwd_state  = fwd_q;
        override_o = 1'b0;
        nbr_err_o  = 1'b0;
        up_msg_o   = SAFE_CODE;
        dn_msg_o   = SAFE_CODE;
        unique case (st_q)
            ARB_RUN: begin
                fwd_state = fwd_q;
            end
            ARB_LATCHED: begin
                fwd_state  = own_q;
                override_o = 1'b1;
                nbr_err_o  = tell_q;
                up_msg_o   = tell_q ? up_q : SAFE_CODE;
                dn_msg_o   = tell_q ? dn_q : SAFE_CODE;
            end
            default: begin
                fwd_state = SAFE_CODE;
            end
        endcase
    end

endmodule

// File: rtl/unit_guard.sv
module unit_guard
    import unit_guard_pkg::*;
#(
    parameter int      PWM_W   = 12,
    parameter int      ENC_W   = 16,
    parameter ustate_t UP_CODE = 4'hA,
    parameter ustate_t DN_CODE = 4'hB
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic signed [PWM_W-1:0] pwm_cmd,
    input  logic        [PWM_W-2:0] pwm_limit,
    input  logic signed [ENC_W-1:0] enc_pos,
    input  logic signed [ENC_W-1:0] enc_min,
    input  logic signed [ENC_W-1:0] enc_max,
    input  logic                    sw_hi,
    input  logic                    sw_lo,
    input  logic                    prev_err_in,
    input  logic                    next_err_in,
    input  logic                    ui_valid,
    input  logic [3:0]              ui_state,
    input  logic                    ctl_valid,
    input  logic [3:0]              ctl_state,
    input  logic                    clear_req,
    output logic [3:0]              fwd_state,
    output logic                    override_o,
    output logic                    prev_err_o,
    output logic [3:0]              prev_msg,
    output logic                    next_err_o,
    output logic [3:0]              next_msg
);

    logic [N_FAULTS-1:0] fault_vec;
    logic                fault_any;
    logic                fault_local;
    ustate_t             own_msg, up_msg, dn_msg;
    logic                nbr_err;

    guard_catcher #(
        .PWM_W (PWM_W),
        .ENC_W (ENC_W)
    ) u_catch (
        .clk         (clk),
        .rst_n       (rst_n),
        .pwm_cmd     (pwm_cmd),
        .pwm_limit   (pwm_limit),
        .enc_pos     (enc_pos),
        .enc_min     (enc_min),
        .enc_max     (enc_max),
        .sw_hi       (sw_hi),
        .sw_lo       (sw_lo),
        .prev_err_in (prev_err_in),
        .next_err_in (next_err_in),
        .fault_q     (fault_vec)
    );

    guard_mapper #(
        .UP_CODE (UP_CODE),
        .DN_CODE (DN_CODE)
    ) u_map (
        .fault_vec (fault_vec),
        .any_fault (fault_any),
        .local_hit (fault_local),
        .own_msg   (own_msg),
        .up_msg    (up_msg),
        .dn_msg    (dn_msg)
    );

    guard_arbiter u_arb (
        .clk        (clk),
        .rst_n      (rst_n),
        .any_fault  (fault_any),
        .local_hit  (fault_local),
        .own_msg    (own_msg),
        .up_msg     (up_msg),
        .dn_msg     (dn_msg),
        .clear_req  (clear_req),
        .ui_valid   (ui_valid),
        .ui_state   (ui_state),
        .ctl_valid  (ctl_valid),
        .ctl_state  (ctl_state),
        .fwd_state  (fwd_state),
        .override_o (override_o),
        .nbr_err_o  (nbr_err),
        .up_msg_o   (prev_msg),
        .dn_msg_o   (next_msg)
    );

    assign prev_err_o = nbr_err;
    assign next_err_o = nbr_err;

endmodule

// File: rtl/unit_guard_chk.sv
module unit_guard_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       fault_any,
    input logic       clear_req,
    input logic       ui_valid,
    input logic [3:0] ui_state,
    input logic [3:0] fwd_state,
    input logic       override_o,
    input logic       prev_err_o,
    input logic       next_err_o,
    input logic [3:0] prev_msg,
    input logic [3:0] next_msg
);

    // R7
    latched_forwards_safe_chk: assert property (@(posedge clk) disable iff (!rst_n)
        override_o |-> fwd_state == 4'h0);

    // R6
    trip_next_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (fault_any && !override_o) |=> override_o);

    // R10
    latch_holds_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (override_o && !(clear_req && !fault_any)) |=> override_o);

    // R10
    release_to_safe_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(override_o) |-> (fwd_state == 4'h0));

    // R8
    err_lines_agree_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (prev_err_o == next_err_o) && (!prev_err_o || override_o));

    // R8
    quiet_msgs_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !prev_err_o |-> (prev_msg == 4'h0 && next_msg == 4'h0));

    // R2
    ui_loads_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!override_o && !fault_any && ui_valid) |=> fwd_state == $past(ui_state));

endmodule

bind unit_guard unit_guard_chk u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .fault_any  (fault_any),
    .clear_req  (clear_req),
    .ui_valid   (ui_valid),
    .ui_state   (ui_state),
    .fwd_state  (fwd_state),
    .override_o (override_o),
    .prev_err_o (prev_err_o),
    .next_err_o (next_err_o),
    .prev_msg   (prev_msg),
    .next_msg   (next_msg)
);

// File: tb/unit_guard_test.sv
`timescale 1ns/1ps
module unit_guard_test;

    logic        clk = 1'b0;
    logic        rst_n;
    logic [11:0] pwm_cmd;
    logic [10:0] pwm_limit;
    logic [15:0] enc_pos, enc_min, enc_max;
    logic        sw_hi, sw_lo, prev_err_in, next_err_in;
    logic        ui_valid, ctl_valid, clear_req;
    logic [3:0]  ui_state, ctl_state;
    logic [3:0]  fwd_state, prev_msg, next_msg;
    logic        override_o, prev_err_o, next_err_o;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 1'b0;

    always #10 clk = ~clk;

    unit_guard uut (
        .clk(clk), .rst_n(rst_n), .pwm_cmd(pwm_cmd), .pwm_limit(pwm_limit),
        .enc_pos(enc_pos), .enc_min(enc_min), .enc_max(enc_max),
        .sw_hi(sw_hi), .sw_lo(sw_lo), .prev_err_in(prev_err_in),
        .next_err_in(next_err_in), .ui_valid(ui_valid), .ui_state(ui_state),
        .ctl_valid(ctl_valid), .ctl_state(ctl_state), .clear_req(clear_req),
        .fwd_state(fwd_state), .override_o(override_o), .prev_err_o(prev_err_o),
        .prev_msg(prev_msg), .next_err_o(next_err_o), .next_msg(next_msg)
    );

    typedef struct packed {
        logic [11:0] pwm;
        logic [15:0] enc;
        logic        hi, lo, pin, nin;
        logic        uv;
        logic [3:0]  us;
        logic        cv;
        logic [3:0]  cs;
        logic        clr;
        logic [3:0]  e_fwd;
        logic        e_ovr, e_err;
        logic [3:0]  e_pm, e_nm;
        logic [7:0]  tag;
    } vec_t;

    // Each row is held for three edges, then the outputs are compared.
    localparam vec_t VEC [24] = '{
        // R2 controller request
        '{12'h000,16'h0000,1'b0,1'b0,1'b0,1'b0,1'b0,4'h0,1'b1,4'h3,1'b0, 4'h3,1'b0,1'b0,4'h0,4'h0,8'd2},
        // R2 user beats controller
        '{12'h000,16'h0000,1'b0,1'b0,1'b0,1'b0,1'b1,4'h5,1'b1,4'h3,1'b0, 4'h5,1'b0,1'b0,4'h0,4'h0,8'd2},
        // R3 magnitude equal to limit
        '{12'h064,16'h0000,1'b0,1'b0,1'b0,1'b0,1'b0,4'h0,1'b0,4'h0,1'b0, 4'h5,1'b0,1'b0,4'h0,4'h0,8'd3},
        // R3 R8 over limit
        '{12'h065,16'h0000,1'b0,1'b0,1'b0,1'b0,1'b0,4'h0,1'b0,4'h0,1'b0, 4'h0,1'b1,1'b1,4'hA,4'hB,8'd3},
        // R7 user command ignored while latched
        '{12'h000,16'h0000,1'b0,1'b0,1'b0,1'b0,1'b1,4'h7,1'b0,4'h0,1'b0, 4'h0,1'b1,1'b1,4'hA,4'hB,8'd7},
        // R10 clear
        '{12'h000,16'h0000,1'b0,1'b0,1'b0,1'b0,1'b0,4'h0,1'b0,4'h0,1'b1, 4'h0,1'b0,1'b0,4'h0,4'h0,8'd10},
        // R2
        '{12'h000,16'h0000,1'b0,1'b0,1'b0,1'b0,1'b0,4'h0,1'b1,4'h2,1'b0, 4'h2,1'b0,1'b0,4'h0,4'h0,8'd2},
        // R4 above max
        '{12'h000,16'h01F5,1'b0,1'b0,1'b0,1'b0,1'b0,4'h0,1'b0,4'h0,1'b0, 4'h0,1'b1,1'b1,4'hA,4'hB,8'd4},
        // R10 clear refused while fault persists
        '{12'h000,16'h01F5,1'b0,1'b0,1'b0,1'b0,1'b0,4'h0,1'b0,4'h0,1'b1, 4'h0,1'b1,1'b1,4'hA,4'hB,8'd10},
        // R10 R4 max itself is legal, clear releases
        '{12'h000,16'h01F4,1'b0,1'b0,1'b0,1'b0,1'b0,4'h0,1'b0,4'h0,1'b1, 4'h0,1'b0,1'b0,4'h0,4'h0,8'd10},
        // R3 negative over limit (-101)
        '{12'hF9B,16'h0000,1'b0,1'b0,1'b0,1'b0,1'b0,4'h0,1'b0,4'h0,1'b0, 4'h0,1'b1,1'b1,4'hA,4'hB,8'd3},
        // R10
        '{12'h000,16'h0000,1'b0,1'b0,1'b0,1'b0,1'b0,4'h0,1'b0,4'h0,1'b1, 4'h0,1'b0,1'b0,4'h0,4'h0,8'd10},
        // R9 upstream error, no echo
        '{12'h000,16'h0000,1'b0,1'b0,1'b1,1'b0,1'b0,4'h0,1'b0,4'h0,1'b0, 4'h0,1'b1,1'b0,4'h0,4'h0,8'd9},
        // R9 local end-switch fault upgrades latch
        '{12'h032,16'h0000,1'b1,1'b0,1'b1,1'b0,1'b0,4'h0,1'b0,4'h0,1'b0, 4'h0,1'b1,1'b1,4'hA,4'hB,8'd9},
        // R10
        '{12'h000,16'h0000,1'b0,1'b0,1'b0,1'b0,1'b0,4'h0,1'b0,4'h0,1'b1, 4'h0,1'b0,1'b0,4'h0,4'h0,8'd10},
        // R5 moving away from high switch
        '{12'hFEC,16'h0000,1'b1,1'b0,1'b0,1'b0,1'b0,4'h0,1'b1,4'h4,1'b0, 4'h4,1'b0,1'b0,4'h0,4'h0,8'd5},
        // R5 moving into low switch
        '{12'hFEC,16'h0000,1'b0,1'b1,1'b0,1'b0,1'b0,4'h0,1'b0,4'h0,1'b0, 4'h0,1'b1,1'b1,4'hA,4'hB,8'd5},
        // R10
        '{12'h000,16'h0000,1'b0,1'b0,1'b0,1'b0,1'b0,4'h0,1'b0,4'h0,1'b1, 4'h0,1'b0,1'b0,4'h0,4'h0,8'd10},
        // R9 downstream error
        '{12'h000,16'h0000,1'b0,1'b0,1'b0,1'b1,1'b0,4'h0,1'b0,4'h0,1'b0, 4'h0,1'b1,1'b0,4'h0,4'h0,8'd9},
        // R10
        '{12'h000,16'h0000,1'b0,1'b0,1'b0,1'b0,1'b0,4'h0,1'b0,4'h0,1'b1, 4'h0,1'b0,1'b0,4'h0,4'h0,8'd10},
        // R4 below min (-501)
        '{12'h000,16'hFE0B,1'b0,1'b0,1'b0,1'b0,1'b0,4'h0,1'b0,4'h0,1'b0, 4'h0,1'b1,1'b1,4'hA,4'hB,8'd4},
        // R10
        '{12'h000,16'h0000,1'b0,1'b0,1'b0,1'b0,1'b0,4'h0,1'b0,4'h0,1'b1, 4'h0,1'b0,1'b0,4'h0,4'h0,8'd10},
        // R3 R4 both bounds exactly (-100, -500)
        '{12'hF9C,16'hFE0C,1'b0,1'b0,1'b0,1'b0,1'b0,4'h0,1'b1,4'h9,1'b0, 4'h9,1'b0,1'b0,4'h0,4'h0,8'd4},
        // R2 user then wins over steady controller
        '{12'h000,16'h0000,1'b0,1'b0,1'b0,1'b0,1'b1,4'h6,1'b1,4'h9,1'b0, 4'h6,1'b0,1'b0,4'h0,4'h0,8'd2}
    };

    function automatic logic [15:0] obs();
        return {fwd_state, override_o, prev_err_o, next_err_o, prev_msg, next_msg, 1'b0};
    endfunction

    task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: got fwd=%h ovr=%b perr=%b nerr=%b pm=%h nm=%h, expected fwd=%h ovr=%b perr=%b nerr=%b pm=%h nm=%h",
                     req, act[15:12], act[11], act[10], act[9], act[8:5], act[4:1],
                     exp[15:12], exp[11], exp[10], exp[9], exp[8:5], exp[4:1]);
        end
    endtask

    task automatic idle_inputs();
        pwm_cmd = '0; enc_pos = '0; sw_hi = 0; sw_lo = 0;
        prev_err_in = 0; next_err_in = 0; ui_valid = 0; ui_state = '0;
        ctl_valid = 0; ctl_state = '0; clear_req = 0;
    endtask

    task automatic finish_run();
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    endtask

    initial begin
        #4_000_000;
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: got running, expected finished");
            finish_run();
        end
    end

    initial begin
        pwm_limit = 11'd100;
        enc_min   = 16'hFE0C;   // -500
        enc_max   = 16'h01F4;   // 500
        idle_inputs();
        rst_n = 1'b0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        // R1 reset state
        check("R1 in reset", obs(), 16'h0000);
        rst_n = 1'b1;
        @(posedge clk);
        @(negedge clk);
        check("R1 after reset", obs(), 16'h0000);

        // Table walk
        for (int i = 0; i < 24; i++) begin
            pwm_cmd = VEC[i].pwm;  enc_pos = VEC[i].enc;
            sw_hi = VEC[i].hi;     sw_lo = VEC[i].lo;
            prev_err_in = VEC[i].pin; next_err_in = VEC[i].nin;
            ui_valid = VEC[i].uv;  ui_state = VEC[i].us;
            ctl_valid = VEC[i].cv; ctl_state = VEC[i].cs;
            clear_req = VEC[i].clr;
            repeat (3) @(posedge clk);
            @(negedge clk);
            check($sformatf("R%0d row %0d", VEC[i].tag, i), obs(),
                  {VEC[i].e_fwd, VEC[i].e_ovr, VEC[i].e_err, VEC[i].e_err,
                   VEC[i].e_pm, VEC[i].e_nm, 1'b0});
        end

        // R6 latency: one edge quiet, trip after the second
        idle_inputs();
        repeat (2) @(negedge clk);
        pwm_cmd = 12'h0C8;
        @(posedge clk); @(negedge clk);
        check("R6 first edge", obs(), {4'h6, 1'b0, 1'b0, 1'b0, 4'h0, 4'h0, 1'b0});
        @(posedge clk); @(negedge clk);
        check("R6 second edge", obs(), {4'h0, 1'b1, 1'b1, 1'b1, 4'hA, 4'hB, 1'b0});

        // R10 clear in the same cycle the condition vanishes: refused, then accepted
        pwm_cmd = '0; clear_req = 1'b1;
        @(posedge clk); @(negedge clk);
        check("R10 clear with stale fault", obs(), {4'h0, 1'b1, 1'b1, 1'b1, 4'hA, 4'hB, 1'b0});
        @(posedge clk); @(negedge clk);
        check("R10 clear accepted", obs(), 16'h0000);
        clear_req = 1'b0;
        repeat (2) @(posedge clk); @(negedge clk);
        check("R10 safe until request", obs(), 16'h0000);

        // R1 reset while latched
        enc_pos = 16'h7000;
        repeat (3) @(posedge clk); @(negedge clk);
        rst_n = 1'b0;
        @(posedge clk); @(negedge clk);
        check("R1 reset clears latch", obs(), 16'h0000);
        enc_pos = '0;
        rst_n = 1'b1;
        repeat (2) @(posedge clk); @(negedge clk);
        check("R1 quiet after reset", obs(), 16'h0000);

        done = 1'b1;
        finish_run();
    end

endmodule